// File: doc/BRIEF.md
# Sleep-State Controller for an 8-bit Microcontroller

This block decides which clocks run in a small 8-bit microcontroller and what the external bus pins show while the core sleeps. Software picks a sleep depth by writing two request bits. The light depth, idle, stops only the CPU clock. The deep depth, power-down, also drops the oscillator enable. Each depth has its own set of wake conditions. A wake from the deep state then waits a fixed, parameterised number of cycles for the oscillator to settle. The CPU clock and interrupt servicing come back only after that wait.

While the core sleeps, the block takes over four bus pins: the address-latch strobe, the program-store strobe, the output enable of the multiplexed low port, and the address/data select of the high port. The levels it forces depend on the sleep depth and on whether code is fetched from internal or external program memory. In the run state these pins simply follow the core's own levels. The block also gates the RAM write enable so that a hardware reset can never corrupt RAM contents. The CPU, the peripherals and the oscillator itself are outside the block and are reached only through ports.

Top module: `sleep_ctrl`

## Requirements
- R1: While `rst_ni` is low, the block is in the run state: `cpu_clk_en_o`, `per_clk_en_o`, `osc_en_o` and `irq_svc_en_o` are 1, `mode_o` is 2'b00, and `ram_we_en_o` is 0. Reset takes effect without waiting for a clock edge.
- R2: In the run state, a cycle with `req_wr_i`=1, `req_idle_i`=1 and `req_pdown_i`=0 enters idle at the next clock edge. Idle means `cpu_clk_en_o`=0, `per_clk_en_o`=1, `osc_en_o`=1 and `mode_o`=2'b01 (bit 0 marks idle). Request bits are ignored when `req_wr_i`=0 and when the block is not in the run state.
- R3: In the run state, a cycle with `req_wr_i`=1 and `req_pdown_i`=1 enters power-down at the next edge, whatever the value of `req_idle_i`. Power-down means `osc_en_o`, `cpu_clk_en_o` and `per_clk_en_o` are all 0 and `mode_o`=2'b10 (bit 1 marks power-down).
- R4: Idle is left at the next edge when any line has both `irq_req_i` and `irq_en_i` set, or both `ext_irq_i` and `ext_en_i` set. Leaving idle returns `mode_o` to 2'b00 and `cpu_clk_en_o` to 1. Requests that are not enabled leave the block in idle.
- R5: Power-down is left only when an external line has `ext_irq_i`, `ext_en_i` and `ext_level_i` all set (`ext_level_i`=1 means level-sensitive), or by reset. Internal interrupts, edge-mode lines and disabled lines leave the block in power-down.
- R6: An interrupt wake from power-down clears `mode_o` and raises `osc_en_o` at the next edge. `cpu_clk_en_o` and `irq_svc_en_o` then stay 0 for exactly `RESTART_CYC` cycles before run resumes.
- R7: A reset asserted during idle, power-down or the restart wait returns the block to run at once and discards the rest of the wait.
- R8: In idle, `ale_o` and `psen_o` are 1. In power-down and during the restart wait, both are 0. In run, they follow `cpu_ale_i` and `cpu_psen_i`.
- R9: In any non-run state, `p0_oe_o` equals the inverse of `ext_code_i` (1 = external program memory), so the low port floats when code is external. In run, `p0_oe_o` follows `cpu_p0_oe_i`.
- R10: `p2_addr_o` is 1 only in idle with `ext_code_i`=1. It is 0 in every other non-run state. In run, it follows `cpu_p2_addr_i`.
- R11: `ram_we_en_o` is 1 only when the block is in run and reset is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Hardware reset, active low, asynchronous |
| req_wr_i | input | 1 | Strobe for a write of the sleep request bits |
| req_idle_i | input | 1 | Idle request bit |
| req_pdown_i | input | 1 | Power-down request bit |
| irq_req_i | input | N_IRQ | Internal interrupt requests |
| irq_en_i | input | N_IRQ | Internal interrupt enables |
| ext_irq_i | input | N_EXT | External interrupt pin levels (1 = active) |
| ext_en_i | input | N_EXT | External interrupt enables |
| ext_level_i | input | N_EXT | 1 = level-sensitive, 0 = edge mode |
| ext_code_i | input | 1 | 1 = code fetched from external program memory |
| cpu_ale_i | input | 1 | Core's address-latch strobe |
| cpu_psen_i | input | 1 | Core's program-store strobe |
| cpu_p0_oe_i | input | 1 | Core's low-port output enable |
| cpu_p2_addr_i | input | 1 | Core's high-port address select |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | 1 | Peripheral clock gate enable |
| osc_en_o | output | 1 | Oscillator enable |
| irq_svc_en_o | output | 1 | Interrupt service passed to the CPU |
| ram_we_en_o | output | 1 | RAM write permission |
| mode_o | output | 2 | Request bits: [0] idle, [1] power-down |
| ale_o | output | 1 | Address-latch strobe at the pin |
| psen_o | output | 1 | Program-store strobe at the pin |
| p0_oe_o | output | 1 | Low-port output enable at the pin |
| p2_addr_o | output | 1 | High port drives address (1) or data (0) |

## Verification
The bound checker watches several rules on every cycle. It checks the clock-enable and strobe levels that go with each request-bit value, and that at most one request bit is ever set. It checks that idle ends one cycle after an enabled request arrives. It checks that power-down holds while no enabled level-sensitive line is active, and that power-down never jumps straight to a running CPU. Some behaviour only the bench's scenarios can show. This covers the exact length of the restart wait, the effect of asynchronous reset in each sleep state, ignored writes, and the four pin-override combinations of memory source and sleep depth.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_IDLE    = 2'd1,
        ST_PDOWN   = 2'd2,
        ST_RESTART = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic ale;
        logic psen;
        logic p0_oe;
        logic p2_addr;
    } pin_lvl_t;

    typedef struct packed {
        logic cpu_clk;
        logic per_clk;
        logic osc;
        logic svc;
    } clk_ctl_t;

endpackage

// File: rtl/sleep_wake.sv
module sleep_wake #(
    parameter int unsigned N_IRQ = 5,
    parameter int unsigned N_EXT = 2
) (
    input  logic [N_IRQ-1:0] irq_req_i,
    input  logic [N_IRQ-1:0] irq_en_i,
    input  logic [N_EXT-1:0] ext_irq_i,
    input  logic [N_EXT-1:0] ext_en_i,
    input  logic [N_EXT-1:0] ext_level_i,
    output logic             idle_wake_o,
    output logic             pd_wake_o
);

    logic [N_EXT-1:0] ext_any;
    logic [N_EXT-1:0] ext_deep;

    // Per external line: any enabled activity wakes idle, only an
    // enabled level-sensitive line can reach the deep state.
    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        assign ext_any[g]  = ext_irq_i[g] & ext_en_i[g];
        assign ext_deep[g] = ext_any[g] & ext_level_i[g];
    end

    assign idle_wake_o = (|(irq_req_i & irq_en_i)) | (|ext_any);
    assign pd_wake_o   = |ext_deep;

endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
    import sleep_pkg::*;
#(
    parameter int unsigned RESTART_CYC = 192000
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      req_wr_i,
    input  logic      req_idle_i,
    input  logic      req_pdown_i,
    input  logic      idle_wake_i,
    input  logic      pd_wake_i,
    output pm_state_e state_o,
    output logic      idle_bit_o,
    output logic      pd_bit_o
);

    localparam int unsigned CNT_W = (RESTART_CYC > 2) ? $clog2(RESTART_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESTART_CYC - 1);

    typedef struct packed {
        pm_state_e        state;
        logic             idle_bit;
        logic             pd_bit;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_RUN: begin
                if (req_wr_i && req_pdown_i) begin
                    r_d.state  = ST_PDOWN;
                    r_d.pd_bit = 1'b1;
                end else if (req_wr_i && req_idle_i) begin
                    r_d.state    = ST_IDLE;
                    r_d.idle_bit = 1'b1;
                end
            end
            ST_IDLE: begin
                if (idle_wake_i) begin
                    r_d.state    = ST_RUN;
                    r_d.idle_bit = 1'b0;
                end
            end
            ST_PDOWN: begin
                if (pd_wake_i) begin
                    r_d.state  = ST_RESTART;
                    r_d.pd_bit = 1'b0;
                    r_d.cnt    = CNT_LOAD;
                end
            end
            ST_RESTART: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_RUN;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: ST_RUN, idle_bit: 1'b0, pd_bit: 1'b0, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o    = r_q.state;
    assign idle_bit_o = r_q.idle_bit;
    assign pd_bit_o   = r_q.pd_bit;

endmodule

// File: rtl/sleep_pins.sv
module sleep_pins
    import sleep_pkg::*;
(
    input  pm_state_e state_i,
    input  logic      ext_code_i,
    input  pin_lvl_t  cpu_lvl_i,
    output pin_lvl_t  pin_lvl_o,
    output clk_ctl_t  clk_ctl_o
);

    always_comb begin
        pin_lvl_o = cpu_lvl_i;
        clk_ctl_o = '{cpu_clk: 1'b1, per_clk: 1'b1, osc: 1'b1, svc: 1'b1};
        unique case (state_i)
            ST_RUN: ;
            ST_IDLE: begin
                pin_lvl_o = '{ale: 1'b1, psen: 1'b1, p0_oe: ~ext_code_i,
                              p2_addr: ext_code_i};
                clk_ctl_o.cpu_clk = 1'b0;
                clk_ctl_o.svc     = 1'b0;
            end
            ST_PDOWN: begin
                pin_lvl_o = '{ale: 1'b0, psen: 1'b0, p0_oe: ~ext_code_i,
                              p2_addr: 1'b0};
                clk_ctl_o = '{cpu_clk: 1'b0, per_clk: 1'b0, osc: 1'b0, svc: 1'b0};
            end
            ST_RESTART: begin
                pin_lvl_o = '{ale: 1'b0, psen: 1'b0, p0_oe: ~ext_code_i,
                              p2_addr: 1'b0};
                clk_ctl_o = '{cpu_clk: 1'b0, per_clk: 1'b0, osc: 1'b1, svc: 1'b0};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
    import sleep_pkg::*;
#(
    parameter int unsigned N_IRQ       = 5,
    parameter int unsigned N_EXT       = 2,
    parameter int unsigned CLK_MHZ     = 12,
    parameter int unsigned WAKE_US     = 16000,
    parameter int unsigned RESTART_CYC = CLK_MHZ * WAKE_US
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_wr_i,
    input  logic             req_idle_i,
    input  logic             req_pdown_i,
    input  logic [N_IRQ-1:0] irq_req_i,
    input  logic [N_IRQ-1:0] irq_en_i,
    input  logic [N_EXT-1:0] ext_irq_i,
    input  logic [N_EXT-1:0] ext_en_i,
    input  logic [N_EXT-1:0] ext_level_i,
    input  logic             ext_code_i,
    input  logic             cpu_ale_i,
    input  logic             cpu_psen_i,
    input  logic             cpu_p0_oe_i,
    input  logic             cpu_p2_addr_i,
    output logic             cpu_clk_en_o,
    output logic             per_clk_en_o,
    output logic             osc_en_o,
    output logic             irq_svc_en_o,
    output logic             ram_we_en_o,
    output logic [1:0]       mode_o,
    output logic             ale_o,
    output logic             psen_o,
    output logic             p0_oe_o,
    output logic             p2_addr_o
);

    logic      idle_wake, pd_wake;
    logic      idle_bit, pd_bit;
    pm_state_e state;
    pin_lvl_t  cpu_lvl, pin_lvl;
    clk_ctl_t  clk_ctl;

    sleep_wake #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) i_wake (
        .irq_req_i   (irq_req_i),
        .irq_en_i    (irq_en_i),
        .ext_irq_i   (ext_irq_i),
        .ext_en_i    (ext_en_i),
        .ext_level_i (ext_level_i),
        .idle_wake_o (idle_wake),
        .pd_wake_o   (pd_wake)
    );

    sleep_fsm #(.RESTART_CYC(RESTART_CYC)) i_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_wr_i    (req_wr_i),
        .req_idle_i  (req_idle_i),
        .req_pdown_i (req_pdown_i),
        .idle_wake_i (idle_wake),
        .pd_wake_i   (pd_wake),
        .state_o     (state),
        .idle_bit_o  (idle_bit),
        .pd_bit_o    (pd_bit)
    );

    assign cpu_lvl = '{ale: cpu_ale_i, psen: cpu_psen_i, p0_oe: cpu_p0_oe_i,
                       p2_addr: cpu_p2_addr_i};

    sleep_pins i_pins (
        .state_i    (state),
        .ext_code_i (ext_code_i),
        .cpu_lvl_i  (cpu_lvl),
        .pin_lvl_o  (pin_lvl),
        .clk_ctl_o  (clk_ctl)
    );

    assign cpu_clk_en_o = clk_ctl.cpu_clk;
    assign per_clk_en_o = clk_ctl.per_clk;
    assign osc_en_o     = clk_ctl.osc;
    assign irq_svc_en_o = clk_ctl.svc;
    assign ram_we_en_o  = rst_ni & (state == ST_RUN);
    assign mode_o       = {pd_bit, idle_bit};
    assign ale_o        = pin_lvl.ale;
    assign psen_o       = pin_lvl.psen;
    assign p0_oe_o      = pin_lvl.p0_oe;
    assign p2_addr_o    = pin_lvl.p2_addr;

endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk #(
    parameter int unsigned N_IRQ = 5,
    parameter int unsigned N_EXT = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [N_IRQ-1:0] irq_req_i,
    input logic [N_IRQ-1:0] irq_en_i,
    input logic [N_EXT-1:0] ext_irq_i,
    input logic [N_EXT-1:0] ext_en_i,
    input logic [N_EXT-1:0] ext_level_i,
    input logic             cpu_clk_en_o,
    input logic             per_clk_en_o,
    input logic             osc_en_o,
    input logic             ram_we_en_o,
    input logic [1:0]       mode_o,
    input logic             ale_o,
    input logic             psen_o
);

    logic any_idle_src, any_deep_src;
    assign any_idle_src = (|(irq_req_i & irq_en_i)) | (|(ext_irq_i & ext_en_i));
    assign any_deep_src = |(ext_irq_i & ext_en_i & ext_level_i);

    AST_MODE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(mode_o)); // R3
    AST_IDLE_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_o == 2'b01 |-> !cpu_clk_en_o && per_clk_en_o && osc_en_o); // R2
    AST_PD_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_o == 2'b10 |-> !osc_en_o && !cpu_clk_en_o && !per_clk_en_o); // R3
    AST_IDLE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'b01 && any_idle_src) |=> mode_o == 2'b00 && cpu_clk_en_o); // R4
    AST_PD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'b10 && !any_deep_src) |=> mode_o == 2'b10); // R5
    AST_PD_NO_DIRECT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_o == 2'b10 |=> !cpu_clk_en_o); // R6
    AST_IDLE_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_o == 2'b01 |-> ale_o && psen_o); // R8
    AST_PD_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !osc_en_o |-> !ale_o && !psen_o); // R8
    AST_RAM_WE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ram_we_en_o |-> cpu_clk_en_o); // R11

endmodule

bind sleep_ctrl sleep_ctrl_chk #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_req_i    (irq_req_i),
    .irq_en_i     (irq_en_i),
    .ext_irq_i    (ext_irq_i),
    .ext_en_i     (ext_en_i),
    .ext_level_i  (ext_level_i),
    .cpu_clk_en_o (cpu_clk_en_o),
    .per_clk_en_o (per_clk_en_o),
    .osc_en_o     (osc_en_o),
    .ram_we_en_o  (ram_we_en_o),
    .mode_o       (mode_o),
    .ale_o        (ale_o),
    .psen_o       (psen_o)
);

// File: tb/test_sleep_ctrl.sv
module test_sleep_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N_IRQ = 5;
    localparam int N_EXT = 2;
    localparam int RCYC  = 20;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic req_wr = 0, req_idle = 0, req_pdown = 0;
    logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
    logic [N_EXT-1:0] ext_irq = '0, ext_en = '0, ext_level = '0;
    logic ext_code = 0, cpu_ale = 0, cpu_psen = 0, cpu_p0_oe = 0, cpu_p2_addr = 0;
    logic cpu_clk_en, per_clk_en, osc_en, irq_svc_en, ram_we_en;
    logic [1:0] mode;
    logic ale, psen, p0_oe, p2_addr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_ctrl #(.N_IRQ(N_IRQ), .N_EXT(N_EXT), .RESTART_CYC(RCYC)) i_sleep_ctrl (
        .clk_i(clk), .rst_ni(rst_ni), .req_wr_i(req_wr), .req_idle_i(req_idle),
        .req_pdown_i(req_pdown), .irq_req_i(irq_req), .irq_en_i(irq_en),
        .ext_irq_i(ext_irq), .ext_en_i(ext_en), .ext_level_i(ext_level),
        .ext_code_i(ext_code), .cpu_ale_i(cpu_ale), .cpu_psen_i(cpu_psen),
        .cpu_p0_oe_i(cpu_p0_oe), .cpu_p2_addr_i(cpu_p2_addr),
        .cpu_clk_en_o(cpu_clk_en), .per_clk_en_o(per_clk_en), .osc_en_o(osc_en),
        .irq_svc_en_o(irq_svc_en), .ram_we_en_o(ram_we_en), .mode_o(mode),
        .ale_o(ale), .psen_o(psen), .p0_oe_o(p0_oe), .p2_addr_o(p2_addr)
    );

    // {ext_code, use_pd, exp_ale, exp_psen, exp_p0_oe, exp_p2_addr}
    localparam logic [5:0] PIN_VEC [4] = '{
        6'b00_1110,
        6'b10_1101,
        6'b01_0010,
        6'b11_0000
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic write_req(input logic idl, input logic pd);
        req_wr = 1; req_idle = idl; req_pdown = pd;
        tick();
        req_wr = 0; req_idle = 0; req_pdown = 0;
    endtask

    task automatic pulse_reset();
        rst_ni = 0;
        #3;
        rst_ni = 1;
        tick();
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1 reset state while reset held
        tick(2);
        chk("R1 cpu_clk", cpu_clk_en, 1);
        chk("R1 osc", osc_en, 1);
        chk("R1 svc", irq_svc_en, 1);
        chk("R1 mode", mode, 0);
        chk("R1 ram_we low in reset", ram_we_en, 0);
        rst_ni = 1;
        tick();
        chk("R11 ram_we in run", ram_we_en, 1);

        // table of pin overrides: R8 R9 R10
        foreach (PIN_VEC[k]) begin
            logic [5:0] v;
            v = PIN_VEC[k];
            ext_code = v[5];
            {cpu_ale, cpu_psen, cpu_p0_oe, cpu_p2_addr} = ~v[3:0];
            write_req(!v[4], v[4]);
            chk("R8 ale", ale, v[3]);
            chk("R8 psen", psen, v[2]);
            chk("R9 p0_oe", p0_oe, v[1]);
            chk("R10 p2_addr", p2_addr, v[0]);
            chk("R11 ram_we sleep", ram_we_en, 0);
            pulse_reset();
            chk("R8 run ale follows", ale, cpu_ale);
            chk("R10 run p2 follows", p2_addr, cpu_p2_addr);
        end

        // R2 idle entry, ignored writes
        req_idle = 1; tick(); req_idle = 0;
        chk("R2 no strobe ignored", mode, 0);
        write_req(1, 0);
        chk("R2 mode idle", mode, 2'b01);
        chk("R2 cpu off", cpu_clk_en, 0);
        chk("R2 per on", per_clk_en, 1);
        write_req(0, 1);
        chk("R2 write in idle ignored", mode, 2'b01);
        // R4 disabled requests do not wake
        irq_req = 5'b00100; irq_en = 5'b01000; ext_irq = 2'b01; ext_en = 2'b10;
        tick(2);
        chk("R4 disabled stays idle", mode, 2'b01);
        irq_en = 5'b00100;
        tick();
        chk("R4 internal wakes idle", mode, 0);
        chk("R4 cpu back", cpu_clk_en, 1);
        irq_req = '0; irq_en = '0; ext_irq = '0; ext_en = '0;
        // R4 edge-mode external line wakes idle
        write_req(1, 0);
        ext_irq = 2'b10; ext_en = 2'b10; ext_level = 2'b00;
        tick();
        chk("R4 ext edge wakes idle", mode, 0);
        ext_irq = '0; ext_en = '0;

        // R3 power-down priority
        write_req(1, 1);
        chk("R3 pd wins", mode, 2'b10);
        chk("R3 osc off", osc_en, 0);
        chk("R3 per off", per_clk_en, 0);
        // R5 non-waking sources
        irq_req = '1; irq_en = '1; tick(2);
        chk("R5 internal no wake", mode, 2'b10);
        irq_req = '0; irq_en = '0;
        ext_irq = 2'b01; ext_en = 2'b01; ext_level = 2'b00; tick(2);
        chk("R5 edge no wake", mode, 2'b10);
        ext_en = 2'b00; ext_level = 2'b01; tick(2);
        chk("R5 disabled no wake", mode, 2'b10);
        // R6 wake and restart wait
        ext_en = 2'b01; tick();
        ext_irq = '0; ext_en = '0; ext_level = '0;
        chk("R6 mode cleared", mode, 0);
        chk("R6 osc on", osc_en, 1);
        chk("R6 cpu held", cpu_clk_en, 0);
        chk("R6 svc held", irq_svc_en, 0);
        chk("R8 restart strobes", {ale, psen}, 0);
        tick(RCYC - 1);
        chk("R6 still waiting", cpu_clk_en, 0);
        tick();
        chk("R6 run after wait", cpu_clk_en, 1);
        chk("R6 svc after wait", irq_svc_en, 1);

        // R7 reset during sleep states
        write_req(0, 1);
        rst_ni = 0; #1;
        chk("R7 reset from pd", {mode, cpu_clk_en, osc_en}, 4'b0011);
        #2; rst_ni = 1; tick();
        write_req(0, 1);
        ext_irq = 2'b10; ext_en = 2'b10; ext_level = 2'b10; tick();
        ext_irq = '0; ext_en = '0; ext_level = '0;
        tick(3);
        rst_ni = 0; #1;
        chk("R7 reset in restart", cpu_clk_en, 1);
        #2; rst_ni = 1; tick();
        write_req(0, 1);
        chk("R7 fresh pd after reset", mode, 2'b10);
        rst_ni = 0; #3; rst_ni = 1; tick();
        write_req(1, 0);
        rst_ni = 0; #1;
        chk("R7 reset from idle", mode, 0);
        #2; rst_ni = 1; tick();

        finish_run();
    end

endmodule